// File: doc/BRIEF.md
# Composite Sync Separator

This block takes external active-low sync and turns it into clean timing strobes for a display pipeline. A mode input selects the source. In separate mode, horizontal and vertical sync arrive on their own pins. In composite mode, both are carried on the horizontal pin and the vertical pin is ignored. Both pins pass through a two-flop synchronizer first. A pulse meter then times every low pulse on the horizontal pin in reference-clock cycles. Each finished pulse is put into one of these classes: glitch, horizontal, stray, broad (vertical) or overlong. All thresholds are parameters given in reference-clock cycles.

The pulse meter is a three-state machine:

- `MS_HIGH`: the line is idle.
  - `HIGH->LOW`: taken on a low sample; the count is loaded with 1.
- `MS_LOW`: a pulse is being counted.
  - `LOW->HIGH`: taken when the line returns high; the width is classified.
  - `LOW->LONG`: taken when the count has reached the maximum broad width and the line is still low.
- `MS_LONG`: an overlong pulse is waiting to end.
  - `LONG->HIGH`: taken when the line returns high; no event is raised.

The vertical tracker is a two-state machine and is used only in composite mode:

- `VT_OFF`: no vertical sync.
  - `OFF->ON`: taken when a pulse has stayed low for the minimum broad width.
- `VT_ON`: vertical sync is asserted.
  - `ON->OFF`: taken on any of the following:
    - a horizontal, stray or overlong pulse event;
    - the line staying high for the idle limit;
    - composite mode being left.

An optional filter makes pulses shorter than the glitch width invisible to the tracker.

Top module: `csync_sep`

## Requirements
- R1: While `rst_n` is low, and after its release before any pulse, `h_strobe` and `v_sync` are 0.
- R2: A low pulse on `hsync_n` lasting W cycles, with H_MIN ≤ W ≤ H_MAX (both ends inclusive), gives exactly one `h_strobe`, one cycle wide, in either mode.
- R3: Pulses of H_MIN-1 or H_MAX+1 cycles give no `h_strobe`.
- R4: In composite mode `v_sync` rises while the pulse is still low: it is 0 before the pulse has been low for V_MIN-4 cycles and 1 once it has been low for V_MIN+4 cycles.
- R5: In composite mode, pulses of V_MIN to V_MAX cycles (both inclusive) keep `v_sync` at 1. The first pulse that ends as horizontal or stray clears it. A stray pulse is one that is not a glitch, lies outside the horizontal window and is shorter than V_MIN.
- R6: A pulse that stays low beyond V_MAX cycles clears `v_sync` while it is still low and gives no `h_strobe`.
- R7: In composite mode, with `v_sync` at 1, a high line lasting IDLE_MAX cycles clears `v_sync`.
- R8: With `glitch_filt_en`=1, a pulse shorter than GLITCH cycles leaves `v_sync` unchanged. With `glitch_filt_en`=0, the same pulse counts as stray and clears `v_sync`.
- R9: In composite mode (`comp_mode`=1), `vsync_n` has no effect on `v_sync`.
- R10: In separate mode (`comp_mode`=0), `v_sync` equals the inverted `vsync_n`, delayed by two clock edges, and broad pulses on `hsync_n` do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; thresholds are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_mode | input | 1 | 1: composite sync on `hsync_n`; 0: separate sync |
| glitch_filt_en | input | 1 | 1: pulses shorter than GLITCH cycles are ignored |
| hsync_n | input | 1 | Active-low horizontal or composite sync |
| vsync_n | input | 1 | Active-low vertical sync, used in separate mode only |
| h_strobe | output | 1 | One-cycle strobe for each valid horizontal pulse |
| v_sync | output | 1 | Active-high regenerated vertical sync |

## Verification
The bench overrides the thresholds with small values:

- GLITCH = 6
- H_MIN = 8, H_MAX = 16
- V_MIN = 26, V_MAX = 56
- IDLE_MAX = 200

With these values, every window edge, the overlong cut-off and the idle release can be reached within a few hundred cycles. The windows are kept disjoint and ordered, as the defaults are. As a result, glitch, stray, horizontal, broad and overlong pulses can each be produced by width alone, and the cases one cycle either side of each horizontal bound are exercised.

// File: rtl/csep_pkg.sv
package csep_pkg;

    typedef enum logic [1:0] {
        MS_HIGH,
        MS_LOW,
        MS_LONG
    } meter_state_e;

    typedef enum logic [2:0] {
        PK_GLITCH,
        PK_HORIZ,
        PK_STRAY,
        PK_BROAD,
        PK_OVERLONG
    } pulse_kind_e;

    typedef enum logic {
        VT_OFF,
        VT_ON
    } vtrack_state_e;

endpackage

// File: rtl/csep_sync.sv
module csep_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_n,
    output logic [WIDTH-1:0] line_lo
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '1;
                else        stage_q[0] <= din_n;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign line_lo = ~stage_q[STAGES-1];

endmodule

// File: rtl/csep_pulse_meter.sv
module csep_pulse_meter
    import csep_pkg::*;
#(
    parameter int unsigned GLITCH_CYC = 12,
    parameter int unsigned H_MIN_CYC  = 16,
    parameter int unsigned H_MAX_CYC  = 32,
    parameter int unsigned V_MIN_CYC  = 52,
    parameter int unsigned V_MAX_CYC  = 112
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        filt_en,
    input  logic        line_lo,
    output logic        ev_valid,
    output pulse_kind_e ev_kind,
    output logic        broad_start
);

    localparam int unsigned CW = $clog2(V_MAX_CYC + 2);
    localparam logic [CW-1:0] GLITCH_C = CW'(GLITCH_CYC);
    localparam logic [CW-1:0] H_MIN_C  = CW'(H_MIN_CYC);
    localparam logic [CW-1:0] H_MAX_C  = CW'(H_MAX_CYC);
    localparam logic [CW-1:0] V_MIN_C  = CW'(V_MIN_CYC);
    localparam logic [CW-1:0] V_MAX_C  = CW'(V_MAX_CYC);
    localparam logic [CW-1:0] V_ARM_C  = CW'(V_MIN_CYC - 1);

    meter_state_e  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ev_d, bstart_d;
    pulse_kind_e   kind_d;

    function automatic pulse_kind_e classify(input logic [CW-1:0] w, input logic filt);
        if (filt && (w < GLITCH_C))                 return PK_GLITCH;
        else if ((w >= H_MIN_C) && (w <= H_MAX_C))  return PK_HORIZ;
        else if (w >= V_MIN_C)                      return PK_BROAD;
        else                                        return PK_STRAY;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_HIGH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        ev_d     = 1'b0;
        kind_d   = PK_GLITCH;
        bstart_d = 1'b0;
        unique case (state_q)
            MS_HIGH: begin
                if (line_lo) begin
                    state_d = MS_LOW;
                    cnt_d   = CW'(1);
                end
            end
            MS_LOW: begin
                if (!line_lo) begin
                    state_d = MS_HIGH;
                    ev_d    = 1'b1;
                    kind_d  = classify(cnt_q, filt_en);
                end else if (cnt_q == V_MAX_C) begin
                    state_d = MS_LONG;
                    ev_d    = 1'b1;
                    kind_d  = PK_OVERLONG;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == V_ARM_C) bstart_d = 1'b1;
                end
            end
            MS_LONG: begin
                if (!line_lo) state_d = MS_HIGH;
            end
            default: state_d = MS_HIGH;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_valid    <= 1'b0;
            ev_kind     <= PK_GLITCH;
            broad_start <= 1'b0;
        end else begin
            ev_valid    <= ev_d;
            ev_kind     <= kind_d;
            broad_start <= bstart_d;
        end
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_LOW) |-> ((cnt_q >= CW'(1)) && (cnt_q <= V_MAX_C))); // R6

    AST_LONG_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_LONG) |=> !(ev_valid && (ev_kind == PK_HORIZ))); // R6

    AST_BROAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        broad_start |=> !broad_start); // R4

endmodule

// File: rtl/csep_vtrack.sv
module csep_vtrack
    import csep_pkg::*;
#(
    parameter int unsigned IDLE_MAX_CYC = 768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        line_lo,
    input  logic        ev_valid,
    input  pulse_kind_e ev_kind,
    input  logic        broad_start,
    output logic        v_on
);

    localparam int unsigned IW = $clog2(IDLE_MAX_CYC + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_MAX_CYC - 1);

    vtrack_state_e state_q, state_d;
    logic [IW-1:0] idle_q, idle_d;
    logic          ends_vert;

    assign ends_vert = ev_valid &&
        ((ev_kind == PK_HORIZ) || (ev_kind == PK_STRAY) || (ev_kind == PK_OVERLONG));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VT_OFF;
            idle_q  <= '0;
        end else begin
            state_q <= state_d;
            idle_q  <= idle_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        idle_d  = idle_q;
        if (line_lo || (state_q == VT_OFF)) idle_d = '0;
        else if (idle_q != IDLE_LAST)       idle_d = idle_q + IW'(1);
        if (!enable) begin
            state_d = VT_OFF;
        end else begin
            unique case (state_q)
                VT_OFF: if (broad_start) state_d = VT_ON;
                VT_ON: begin
                    if (ends_vert)                                state_d = VT_OFF;
                    else if (!line_lo && (idle_q == IDLE_LAST))   state_d = VT_OFF;
                end
                default: state_d = VT_OFF;
            endcase
        end
    end

    // output
    always_comb v_on = (state_q == VT_ON);

    AST_RISE_AFTER_BROAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_on) |-> $past(broad_start)); // R4

    AST_HORIZ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_kind == PK_HORIZ)) |=> !v_on); // R5

    AST_OVERLONG_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_kind == PK_OVERLONG)) |=> !v_on); // R6

    AST_GLITCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (v_on && enable && ev_valid && (ev_kind == PK_GLITCH) && !line_lo && (idle_q != IDLE_LAST))
        |=> v_on); // R8

    AST_OFF_IN_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !v_on); // R10

endmodule

// File: rtl/csync_sep.sv
module csync_sep
    import csep_pkg::*;
#(
    parameter int unsigned GLITCH_CYC   = 12,
    parameter int unsigned H_MIN_CYC    = 16,
    parameter int unsigned H_MAX_CYC    = 32,
    parameter int unsigned V_MIN_CYC    = 52,
    parameter int unsigned V_MAX_CYC    = 112,
    parameter int unsigned IDLE_MAX_CYC = 768,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comp_mode,
    input  logic glitch_filt_en,
    input  logic hsync_n,
    input  logic vsync_n,
    output logic h_strobe,
    output logic v_sync
);

    localparam int unsigned NLINES = 2;

    logic [NLINES-1:0] line_lo;
    logic              ev_valid;
    pulse_kind_e       ev_kind;
    logic              broad_start;
    logic              v_on;

    csep_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_n   ({vsync_n, hsync_n}),
        .line_lo (line_lo)
    );

    csep_pulse_meter #(
        .GLITCH_CYC (GLITCH_CYC),
        .H_MIN_CYC  (H_MIN_CYC),
        .H_MAX_CYC  (H_MAX_CYC),
        .V_MIN_CYC  (V_MIN_CYC),
        .V_MAX_CYC  (V_MAX_CYC)
    ) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .filt_en     (glitch_filt_en),
        .line_lo     (line_lo[0]),
        .ev_valid    (ev_valid),
        .ev_kind     (ev_kind),
        .broad_start (broad_start)
    );

    csep_vtrack #(.IDLE_MAX_CYC(IDLE_MAX_CYC)) u_vtrack (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (comp_mode),
        .line_lo     (line_lo[0]),
        .ev_valid    (ev_valid),
        .ev_kind     (ev_kind),
        .broad_start (broad_start),
        .v_on        (v_on)
    );

    assign h_strobe = ev_valid && (ev_kind == PK_HORIZ);
    assign v_sync   = comp_mode ? v_on : line_lo[1];

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        h_strobe |=> !h_strobe); // R2

    AST_NO_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_mode && $past(comp_mode) && $rose(v_sync)) |-> !h_strobe); // R5

endmodule

// File: tb/csync_sep_bench.sv
module csync_sep_bench;

    localparam int CLK_PERIOD = 10;
    localparam int GLITCH = 6;
    localparam int H_MIN  = 8;
    localparam int H_MAX  = 16;
    localparam int V_MIN  = 26;
    localparam int V_MAX  = 56;
    localparam int IDLE   = 200;
    localparam int GAP    = 20;
    localparam int NVEC   = 16;

    // fields: filter enable, pulse width, expected strobes, expected v_sync, requirement number
    localparam int VEC [NVEC][5] = '{
        '{1, 12,    1, 0, 2},   // R2 mid window
        '{1, H_MIN, 1, 0, 2},   // R2 lower bound
        '{1, H_MAX, 1, 0, 2},   // R2 upper bound
        '{1, H_MIN-1, 0, 0, 3}, // R3 below
        '{1, H_MAX+1, 0, 0, 3}, // R3 above
        '{1, 30,    0, 1, 4},   // R4 broad declares
        '{1, 30,    0, 1, 5},   // R5 broad holds
        '{1, 3,     0, 1, 8},   // R8 glitch filtered
        '{1, 12,    1, 0, 5},   // R5 horizontal releases
        '{1, 30,    0, 1, 5},
        '{0, 3,     0, 0, 8},   // R8 unfiltered short pulse releases
        '{1, 30,    0, 1, 5},
        '{1, 20,    0, 0, 5},   // R5 stray releases
        '{1, V_MIN, 0, 1, 5},   // R5 lower broad bound
        '{1, V_MAX, 0, 1, 5},   // R5 upper broad bound
        '{1, 12,    1, 0, 5}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic comp_mode = 1'b1;
    logic glitch_filt_en = 1'b1;
    logic hsync_n = 1'b1;
    logic vsync_n = 1'b1;
    logic h_strobe, v_sync;

    int checks = 0;
    int fails  = 0;
    int hcnt   = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csync_sep #(
        .GLITCH_CYC(GLITCH), .H_MIN_CYC(H_MIN), .H_MAX_CYC(H_MAX),
        .V_MIN_CYC(V_MIN), .V_MAX_CYC(V_MAX), .IDLE_MAX_CYC(IDLE)
    ) u_csync_sep (
        .clk(clk), .rst_n(rst_n), .comp_mode(comp_mode),
        .glitch_filt_en(glitch_filt_en), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .h_strobe(h_strobe), .v_sync(v_sync)
    );

    always @(negedge clk) if (h_strobe) hcnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int w, input int gap);
        @(negedge clk) hsync_n = 1'b0;
        repeat (w) @(negedge clk);
        hsync_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        int h0;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 h_strobe in reset", int'(h_strobe), 0);
        chk("R1 v_sync in reset", int'(v_sync), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 v_sync after reset", int'(v_sync), 0);
        chk("R1 no strobe after reset", hcnt, 0);

        // table walk in composite mode
        for (int i = 0; i < NVEC; i++) begin
            glitch_filt_en = VEC[i][0][0];
            h0 = hcnt;
            pulse(VEC[i][1], GAP);
            chk($sformatf("R%0d vec %0d strobes", VEC[i][4], i), hcnt - h0, VEC[i][2]);
            chk($sformatf("R%0d vec %0d v_sync", VEC[i][4], i), int'(v_sync), VEC[i][3]);
        end
        glitch_filt_en = 1'b1;

        // R4 v_sync rises during the pulse
        @(negedge clk) hsync_n = 1'b0;
        repeat (V_MIN - 4) @(negedge clk);
        chk("R4 before V_MIN", int'(v_sync), 0);
        repeat (8) @(negedge clk);
        chk("R4 after V_MIN", int'(v_sync), 1);
        repeat (6) @(negedge clk);
        hsync_n = 1'b1;
        repeat (GAP) @(negedge clk);

        // R6 overlong pulse clears v_sync while low
        h0 = hcnt;
        @(negedge clk) hsync_n = 1'b0;
        repeat (V_MAX + 8) @(negedge clk);
        chk("R6 cleared while low", int'(v_sync), 0);
        repeat (16) @(negedge clk);
        hsync_n = 1'b1;
        repeat (GAP) @(negedge clk);
        chk("R6 no strobe", hcnt - h0, 0);
        chk("R6 stays clear", int'(v_sync), 0);

        // R7 idle timeout
        pulse(30, 150);
        chk("R7 held before idle limit", int'(v_sync), 1);
        repeat (70) @(negedge clk);
        chk("R7 released after idle limit", int'(v_sync), 0);

        // R9 vsync ignored in composite mode
        @(negedge clk) vsync_n = 1'b0;
        repeat (20) @(negedge clk);
        chk("R9 vsync ignored", int'(v_sync), 0);
        vsync_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 separate mode
        comp_mode = 1'b0;
        repeat (2) @(negedge clk);
        vsync_n = 1'b0;
        @(negedge clk);
        chk("R10 one edge latency", int'(v_sync), 0);
        @(negedge clk);
        chk("R10 two edge latency", int'(v_sync), 1);
        repeat (5) @(negedge clk);
        vsync_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 follows release", int'(v_sync), 0);
        h0 = hcnt;
        @(negedge clk) hsync_n = 1'b0;
        repeat (V_MIN + 6) @(negedge clk);
        chk("R10 broad hsync no v", int'(v_sync), 0);
        hsync_n = 1'b1;
        repeat (GAP) @(negedge clk);
        chk("R10 broad hsync no strobe", hcnt - h0, 0);
        h0 = hcnt;
        pulse(12, GAP);
        chk("R2 separate mode strobe", hcnt - h0, 1);

        done = 1'b1;
        finish_run();
    end

endmodule